// File: doc/BRIEF.md
# Debug Instruction Injection Unit

This block lets a debug host run single instructions on a processor core that is halted in debug state. The host first loads a 48-bit command word. It then raises go, with an optional exit flag. The block splits the command word into instruction-bus words, which are an optional prefix, the opcode, and zero to two immediate words. It sends them in order over a valid/ready handshake and then waits for the core to report completion.

After completion the block either returns to idle while still in debug state, or leaves debug state if the exit flag came with go. Any exception that the core raises while an injected instruction runs is held back. It is presented to the core as a one-cycle pulse only when debug state is left. A core debug-entry strobe puts the block back into debug state.

Top module: `dbg_inject_unit`

## Requirements
- R1: Command word layout:
  - Bits [1:0] are the length code (01, 10 or 11 for one, two or three instruction words).
  - Bits [3:2] are the prefix extension.
  - Bits [19:4] are the opcode.
  - Bits [33:20] are the first immediate.
  - Bits [47:34] are the second immediate.
  - Words go out in the order prefix (if any), opcode, first immediate word, second immediate word, and ib_last_o marks the final word.
- R2: A prefix word is sent only when the extension is nonzero. Its value is 16'hA000 with bit 5 set to command bit 3 and bit 7 set to command bit 2.
- R3: Each immediate word carries the 14-bit immediate in bits 13:0 and the grouping code 2'b10 in bits 15:14.
- R4: While ib_valid_o is high and ib_ready_i is low, ib_valid_o and ib_data_o hold their values.
- R5: go_i in debug state while idle starts an injection. busy_o is high from the next cycle until the block returns to idle.
- R6: go_i with length code 00 issues nothing, leaves busy_o low and sets err_o. The next accepted go with a valid length clears err_o.
- R7: After done_i, the block takes one more cycle, then returns to idle. debug_o stays high unless the exit flag was given with go, in which case debug_o falls.
- R8: go_i while busy_o is high is ignored and sets the sticky ovr_o. ovr_clr_i clears ovr_o.
- R9: An exception (exc_i) raised during an injection is held pending across any number of injections that do not exit. On exit, exc_o is high for exactly the one cycle before debug_o falls, and the pending state is then cleared.
- R10: A command write while busy_o is high is ignored.
- R11: go_i while debug_o is low is ignored. dbg_enter_i while idle sets debug_o.
- R12: After reset the block is idle and in debug state, with ib_valid_o, err_o, ovr_o and exc_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 48 | Command word write data |
| go_i | input | 1 | Start injection |
| go_exit_i | input | 1 | Leave debug state after this injection (sampled with go_i) |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| dbg_enter_i | input | 1 | Core enters debug state |
| ib_valid_o | output | 1 | Instruction-bus word valid |
| ib_data_o | output | 16 | Instruction-bus word |
| ib_last_o | output | 1 | Final word of the instruction |
| ib_ready_i | input | 1 | Core accepts the word |
| done_i | input | 1 | Core finished the injected instruction |
| exc_i | input | 1 | Core raised an exception |
| exc_o | output | 1 | Deferred exception released on exit |
| busy_o | output | 1 | Injection in progress |
| debug_o | output | 1 | Block is in debug state |
| err_o | output | 1 | Unsupported length code seen at go |
| ovr_o | output | 1 | go arrived while busy (sticky) |

## Verification
The hardest case to reach is a deferred exception that must survive a non-exiting injection and only appear on a later exit. A second hard case is a go and a command write landing while a word is stalled on the bus.

The vector table raises exc_i together with done_i on a non-exiting entry and checks that the pulse appears only on the following exiting entry. A directed test holds ib_ready_i low mid-issue and fires go and a new command write into the stall. It then checks that the words already latched come out unchanged.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;
  localparam int CMD_W  = 48;
  localparam int WORD_W = 16;
  localparam int IMM_W  = 14;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PFX, ST_W0, ST_W1, ST_W2, ST_WAIT, ST_RET, ST_EXIT
  } inj_state_e;

  typedef struct packed {
    logic [1:0]        len;
    logic              has_pfx;
    logic [WORD_W-1:0] pfx;
    logic [WORD_W-1:0] op;
    logic [WORD_W-1:0] wa;
    logic [WORD_W-1:0] wb;
  } inj_words_t;
endpackage

// File: rtl/dbg_cmd_unpack.sv
module dbg_cmd_unpack
  import dbg_inject_pkg::*;
#(
  parameter logic [WORD_W-1:0] PFX_BASE = 16'hA000,
  parameter logic [1:0]        GRP_CODE = 2'b10
) (
  input  logic [CMD_W-1:0] cmd_i,
  output inj_words_t       words_o
);
  localparam int OP_LO = 4;
  localparam int IA_LO = OP_LO + WORD_W;
  localparam int IB_LO = IA_LO + IMM_W;

  always_comb begin
    words_o.len     = cmd_i[1:0];
    words_o.has_pfx = |cmd_i[3:2];
    words_o.pfx     = PFX_BASE;
    words_o.pfx[5]  = cmd_i[3];
    words_o.pfx[7]  = cmd_i[2];
    words_o.op      = cmd_i[OP_LO +: WORD_W];
    words_o.wa      = {GRP_CODE, cmd_i[IA_LO +: IMM_W]};
    words_o.wb      = {GRP_CODE, cmd_i[IB_LO +: IMM_W]};
  end
endmodule

// File: rtl/dbg_inject_fsm.sv
module dbg_inject_fsm
  import dbg_inject_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              go_exit_i,
  input  logic              ovr_clr_i,
  input  logic              dbg_enter_i,
  input  inj_words_t        words_i,
  input  logic              ib_ready_i,
  input  logic              done_i,
  output logic              ib_valid_o,
  output logic [WORD_W-1:0] ib_data_o,
  output logic              ib_last_o,
  output logic              busy_o,
  output logic              debug_o,
  output logic              err_o,
  output logic              ovr_o,
  output logic              exit_o
);
  inj_state_e state_q, state_d;
  logic exit_q, debug_q, err_q, ovr_q, go_ok;

  assign go_ok  = go_i && debug_q && (state_q == ST_IDLE);
  assign busy_o = state_q != ST_IDLE;
  assign exit_o = state_q == ST_EXIT;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_ok && words_i.len != 2'b00)
                 state_d = words_i.has_pfx ? ST_PFX : ST_W0;
      ST_PFX:  if (ib_ready_i) state_d = ST_W0;
      ST_W0:   if (ib_ready_i) state_d = (words_i.len == 2'b01) ? ST_WAIT : ST_W1;
      ST_W1:   if (ib_ready_i) state_d = (words_i.len == 2'b10) ? ST_WAIT : ST_W2;
      ST_W2:   if (ib_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (done_i) state_d = exit_q ? ST_EXIT : ST_RET;
      ST_RET:  state_d = ST_IDLE;
      ST_EXIT: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ib_valid_o = 1'b1;
    ib_data_o  = '0;
    ib_last_o  = 1'b0;
    unique case (state_q)
      ST_PFX: ib_data_o = words_i.pfx;
      ST_W0: begin
        ib_data_o = words_i.op;
        ib_last_o = words_i.len == 2'b01;
      end
      ST_W1: begin
        ib_data_o = words_i.wa;
        ib_last_o = words_i.len == 2'b10;
      end
      ST_W2: begin
        ib_data_o = words_i.wb;
        ib_last_o = 1'b1;
      end
      default: ib_valid_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      exit_q  <= 1'b0;
      debug_q <= 1'b1;
      err_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (go_ok) begin
        exit_q <= go_exit_i;
        err_q  <= words_i.len == 2'b00;
      end
      if (state_q == ST_EXIT) debug_q <= 1'b0;
      else if (dbg_enter_i && state_q == ST_IDLE) debug_q <= 1'b1;
      if (go_i && busy_o) ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign debug_o = debug_q;
  assign err_o   = err_q;
  assign ovr_o   = ovr_q;

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ib_valid_o && !ib_ready_i |=> ib_valid_o && $stable(ib_data_o));
  // R6
  badlen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && debug_o && !busy_o && words_i.len == 2'b00 |=> !busy_o && err_o);
  // R8
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && busy_o |=> ovr_o);
  // R11
  nodbg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && !debug_o && !busy_o |=> !busy_o);
endmodule

// File: rtl/dbg_exc_defer.sv
module dbg_exc_defer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic exc_i,
  input  logic capture_i,
  input  logic release_i,
  output logic exc_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= 1'b0;
    else if (release_i)         pend_q <= 1'b0;
    else if (capture_i && exc_i) pend_q <= 1'b1;
  end

  assign exc_o = release_i && pend_q;

  // R9
  pulse_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> !exc_o);
endmodule

// File: rtl/dbg_inject_unit.sv
module dbg_inject_unit
  import dbg_inject_pkg::*;
#(
  parameter logic [WORD_W-1:0] PFX_BASE = 16'hA000,
  parameter logic [1:0]        GRP_CODE = 2'b10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  input  logic              go_i,
  input  logic              go_exit_i,
  input  logic              ovr_clr_i,
  input  logic              dbg_enter_i,
  output logic              ib_valid_o,
  output logic [WORD_W-1:0] ib_data_o,
  output logic              ib_last_o,
  input  logic              ib_ready_i,
  input  logic              done_i,
  input  logic              exc_i,
  output logic              exc_o,
  output logic              busy_o,
  output logic              debug_o,
  output logic              err_o,
  output logic              ovr_o
);
  logic [CMD_W-1:0] cmd_q;
  inj_words_t       words;
  logic             exit_st;

  // command word is frozen while an injection runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cmd_q <= '0;
    else if (cmd_we_i && !busy_o) cmd_q <= cmd_wdata_i;
  end

  dbg_cmd_unpack #(.PFX_BASE(PFX_BASE), .GRP_CODE(GRP_CODE)) u_unpack (
    .cmd_i   (cmd_q),
    .words_o (words)
  );

  dbg_inject_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go_i),
    .go_exit_i   (go_exit_i),
    .ovr_clr_i   (ovr_clr_i),
    .dbg_enter_i (dbg_enter_i),
    .words_i     (words),
    .ib_ready_i  (ib_ready_i),
    .done_i      (done_i),
    .ib_valid_o  (ib_valid_o),
    .ib_data_o   (ib_data_o),
    .ib_last_o   (ib_last_o),
    .busy_o      (busy_o),
    .debug_o     (debug_o),
    .err_o       (err_o),
    .ovr_o       (ovr_o),
    .exit_o      (exit_st)
  );

  dbg_exc_defer u_exc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exc_i     (exc_i),
    .capture_i (busy_o && !exit_st),
    .release_i (exit_st),
    .exc_o     (exc_o)
  );

  // R9
  exc_on_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> !debug_o && !busy_o);
  // R10
  frozen_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ib_valid_o && !ib_ready_i && cmd_we_i |=> $stable(ib_data_o));
endmodule

// File: tb/tb_dbg_inject_unit.sv
module tb_dbg_inject_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we_i = 1'b0;
  logic [47:0] cmd_wdata_i = '0;
  logic        go_i = 1'b0, go_exit_i = 1'b0, ovr_clr_i = 1'b0, dbg_enter_i = 1'b0;
  logic        ib_ready_i = 1'b0, done_i = 1'b0, exc_i = 1'b0;
  logic        ib_valid_o, ib_last_o, exc_o, busy_o, debug_o, err_o, ovr_o;
  logic [15:0] ib_data_o;

  int n_chk = 0, n_fail = 0;
  bit pend_m = 1'b0;

  always #2 clk_i = ~clk_i;

  dbg_inject_unit dut (.*);

  // {exc, exit, immB, immA, op, ext, len}
  localparam logic [49:0] VEC [6] = '{
    {1'b0, 1'b0, 14'h0000, 14'h0000, 16'h1234, 2'b00, 2'b01},
    {1'b1, 1'b0, 14'h0000, 14'h2AAA, 16'hBEEF, 2'b01, 2'b10},
    {1'b0, 1'b1, 14'h3FFF, 14'h1555, 16'h0F0F, 2'b10, 2'b11},
    {1'b0, 1'b0, 14'h0001, 14'h0000, 16'hFFFF, 2'b11, 2'b11},
    {1'b1, 1'b1, 14'h0000, 14'h0000, 16'h8001, 2'b11, 2'b01},
    {1'b0, 1'b0, 14'h0000, 14'h3FFF, 16'h0000, 2'b00, 2'b10}
  };

  task automatic tick(); @(negedge clk_i); endtask

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_words(input logic [47:0] c, output logic [15:0] w [4]);
    int n = 0;
    w = '{default: '0};
    if (c[3:2] != 2'b00) begin
      w[n] = 16'hA000 | (16'(c[3]) << 5) | (16'(c[2]) << 7);
      n++;
    end
    w[n] = c[19:4]; n++;
    if (c[1:0] >= 2'b10) begin w[n] = {2'b10, c[33:20]}; n++; end
    if (c[1:0] == 2'b11) begin w[n] = {2'b10, c[47:34]}; n++; end
    return n;
  endfunction

  // collect words with ready high, starting at a negedge where issue is under way
  task automatic collect(input logic [47:0] c, input string req);
    logic [15:0] w [4];
    int cnt = exp_words(c, w);
    int n = 0;
    ib_ready_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (!ib_valid_o) break;
      if (n < 4) chk(ib_data_o == w[n], req, ib_data_o, w[n]);
      chk(ib_last_o == (n == cnt - 1), "R1 last", ib_last_o, n == cnt - 1);
      n++;
      tick();
    end
    ib_ready_i = 1'b0;
    chk(n == cnt, "R1 count", n, cnt);
  endtask

  task automatic finish(input bit ex, input bit exc);
    done_i = 1'b1; exc_i = exc;
    if (exc) pend_m = 1'b1;
    tick();
    done_i = 1'b0; exc_i = 1'b0;
    chk(busy_o && debug_o, "R7 last busy", {busy_o, debug_o}, 2'b11);
    chk(exc_o == (ex && pend_m), "R9 exc pulse", exc_o, ex && pend_m);
    tick();
    chk(!busy_o && debug_o == !ex, "R7 end", {busy_o, debug_o}, {1'b0, !ex});
    chk(!exc_o, "R9 single cycle", exc_o, 0);
    if (ex) pend_m = 1'b0;
  endtask

  task automatic start(input logic [47:0] c, input bit ex);
    cmd_we_i = 1'b1; cmd_wdata_i = c;
    tick();
    cmd_we_i = 1'b0; go_i = 1'b1; go_exit_i = ex;
    tick();
    go_i = 1'b0; go_exit_i = 1'b0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(); tick();
    // R12 reset state
    chk(!busy_o && debug_o && !ib_valid_o && !err_o && !ovr_o && !exc_o, "R12 reset",
        {busy_o, debug_o, ib_valid_o, err_o, ovr_o, exc_o}, 6'b010000);
    rst_ni = 1'b1;
    tick();

    // R6 unsupported length
    start(48'h0000_0000_1230, 1'b0);
    chk(!busy_o && !ib_valid_o && err_o, "R6 len00", {busy_o, ib_valid_o, err_o}, 3'b001);
    tick();
    chk(!busy_o && !ib_valid_o, "R6 nothing issued", {busy_o, ib_valid_o}, 0);

    // table walk
    foreach (VEC[i]) begin
      logic [47:0] c = VEC[i][47:0];
      bit ex = VEC[i][48];
      start(c, ex);
      chk(busy_o, "R5 busy", busy_o, 1);
      if (i == 0) chk(!err_o, "R6 err cleared", err_o, 0);
      collect(c, "R1 R2 R3 word");
      finish(ex, VEC[i][49]);
      if (ex) begin
        // R11 go outside debug ignored
        go_i = 1'b1; tick(); go_i = 1'b0;
        chk(!busy_o && !ib_valid_o && !ovr_o, "R11 go ignored", {busy_o, ib_valid_o, ovr_o}, 0);
        dbg_enter_i = 1'b1; tick(); dbg_enter_i = 1'b0;
        chk(debug_o, "R11 re-enter", debug_o, 1);
      end
    end

    // R4 R8 R10 stall with go and write during busy
    begin
      logic [47:0] a = {14'h0ABC, 14'h1DEF, 16'h5A5A, 2'b00, 2'b11};
      start(a, 1'b0);
      chk(ib_valid_o && ib_data_o == 16'h5A5A, "R4 first", ib_data_o, 16'h5A5A);
      go_i = 1'b1; cmd_we_i = 1'b1; cmd_wdata_i = 48'hFFFF_FFFF_FFF5;
      tick();
      go_i = 1'b0; cmd_we_i = 1'b0;
      chk(ovr_o, "R8 overrun set", ovr_o, 1);
      chk(ib_valid_o && ib_data_o == 16'h5A5A, "R4 hold", ib_data_o, 16'h5A5A);
      tick();
      chk(ib_valid_o && ib_data_o == 16'h5A5A, "R4 hold2", ib_data_o, 16'h5A5A);
      collect(a, "R10 words unchanged");
      finish(1'b0, 1'b0);
      chk(ovr_o, "R8 sticky", ovr_o, 1);
      ovr_clr_i = 1'b1; tick(); ovr_clr_i = 1'b0;
      chk(!ovr_o, "R8 cleared", ovr_o, 0);
    end

    // R9 exception pending over two non-exit runs, released on exit
    start({14'h0, 14'h0, 16'h0001, 2'b00, 2'b01}, 1'b0);
    collect({14'h0, 14'h0, 16'h0001, 2'b00, 2'b01}, "R9 run a");
    finish(1'b0, 1'b1);
    start({14'h0, 14'h0, 16'h0002, 2'b00, 2'b01}, 1'b0);
    collect({14'h0, 14'h0, 16'h0002, 2'b00, 2'b01}, "R9 run b");
    finish(1'b0, 1'b0);
    start({14'h0, 14'h0, 16'h0003, 2'b00, 2'b01}, 1'b1);
    collect({14'h0, 14'h0, 16'h0003, 2'b00, 2'b01}, "R9 run c");
    finish(1'b1, 1'b0);
    dbg_enter_i = 1'b1; tick(); dbg_enter_i = 1'b0;
    start({14'h0, 14'h0, 16'h0004, 2'b00, 2'b01}, 1'b1);
    collect({14'h0, 14'h0, 16'h0004, 2'b00, 2'b01}, "R9 run d");
    finish(1'b1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule